// File: doc/BRIEF.md
# Banked Register Address Resolver

This block turns the register operand of an instruction into a physical data-memory address for a small banked register file. A non-zero 5-bit register field addresses bank 0 directly. A field of zero makes the access indirect: the block then forms the address from its own 7-bit pointer register, whose two upper bits pick one of four banks and whose five lower bits pick an offset within that bank.

Only the upper half of each bank (offsets 10h to 1Fh) holds separate storage. The lower half of banks 1 to 3 folds onto bank 0, so special registers and the shared RAM at 08h to 0Fh can be reached from any bank. From the resolved address the block raises one select for the timer, program counter, status word, pointer, the three ports or general-purpose RAM. It also owns the pointer register, which loads from the write data when an access resolves to it. A build parameter drops the third port so that its address becomes RAM.

Top module: `bank_addr_resolver`

## Requirements
- R1: When `regField` is non-zero, `physAddr` equals `{2'b00, regField}`, whatever the pointer holds.
- R2: When `regField` is zero, the access is indirect: the offset is pointer bits 4..0 and the bank is pointer bits 6..5.
- R3: An indirect offset in 00h..0Fh resolves to `physAddr = {3'b000, offset[3:0]}` in every bank.
- R4: An indirect offset in 10h..1Fh resolves to `physAddr = {bank, offset}`, i.e. one of 10h-1Fh, 30h-3Fh, 50h-5Fh, 70h-7Fh.
- R5: The resolved address drives exactly one select: 01h `selTimer`, 02h `selPc`, 03h `selStatus`, 04h `selPtr`, 05h `selPortA`, 06h `selPortB`, 07h `selPortC`, 08h and above `selRam`.
- R6: An indirect access whose pointer offset is 00h raises `nullAcc`, gives `physAddr` 00h with no select, and a write to it leaves the pointer unchanged.
- R7: A write (`accValid` and `accWrite` high) that resolves to 04h, directly or indirectly, loads `wrData` into the pointer at the next clock edge.
- R8: `ptrRdData` is `{1'b1, pointer}`: bit 7 always reads 1.
- R9: After reset the pointer holds 00h, so `ptrRdData` reads 80h.
- R10: With `accValid` or `accWrite` low, or with a target other than 04h, the pointer keeps its value.
- R11: When built with `HAS_PORT_C = 0`, address 07h raises `selRam` and `selPortC` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regField | input | 5 | Register field of the instruction; 0 selects indirect access |
| accValid | input | 1 | An access is made this cycle |
| accWrite | input | 1 | The access writes its target |
| wrData | input | 7 | Value stored into the pointer when it is the write target |
| physAddr | output | 7 | Resolved physical data address |
| selTimer | output | 1 | Target is the timer |
| selPc | output | 1 | Target is the program counter |
| selStatus | output | 1 | Target is the status word |
| selPtr | output | 1 | Target is the pointer register |
| selPortA | output | 1 | Target is port A |
| selPortB | output | 1 | Target is port B |
| selPortC | output | 1 | Target is port C (0 when the port is absent) |
| selRam | output | 1 | Target is general-purpose RAM |
| nullAcc | output | 1 | Indirect access through a pointer offset of 00h |
| ptrRdData | output | 8 | Read value of the pointer register |

## Verification
The bench builds two copies side by side on the same inputs: one with the default `HAS_PORT_C = 1` and one with `HAS_PORT_C = 0`. The first reaches every special select, each bank's folded lower half and separate upper half, and the null indirect target. The second makes address 07h observable as RAM, which the default build can never show.

// File: rtl/bank_addr_pkg.sv
package bank_addr_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic useInd;   // take offset and bank from the pointer
    logic nullAcc;  // indirect access to the pointer-only slot
    logic ptrWe;    // load pointer this edge
  } addrCtrl_t;

  // Fixed slots in the shared lower half of bank 0
  localparam int unsigned SLOT_TIMER  = 1;
  localparam int unsigned SLOT_PC     = 2;
  localparam int unsigned SLOT_STATUS = 3;
  localparam int unsigned SLOT_PTR    = 4;
  localparam int unsigned SLOT_PORTA  = 5;
  localparam int unsigned SLOT_PORTB  = 6;
  localparam int unsigned SLOT_PORTC  = 7;
  localparam int unsigned SLOT_RAM0   = 8;

endpackage

// File: rtl/bank_addr_ctrl.sv
module bank_addr_ctrl
  import bank_addr_pkg::*;
#(
  parameter int unsigned OFS_W = 5
) (
  input  logic [OFS_W-1:0] regField,
  input  logic [OFS_W-1:0] ptrOfs,
  input  logic             accValid,
  input  logic             accWrite,
  output addrCtrl_t        ctrl
);

  logic             indirect;
  logic [OFS_W-1:0] effOfs;
  logic             hitsPtr;

  always_comb begin
    indirect = (regField == '0);
    effOfs   = indirect ? ptrOfs : regField;
    // The pointer slot sits in the folded half, so the bank does not matter
    hitsPtr  = (effOfs == OFS_W'(SLOT_PTR));
    ctrl.useInd  = indirect;
    ctrl.nullAcc = indirect && (ptrOfs == '0);
    ctrl.ptrWe   = accValid && accWrite && hitsPtr;
  end

endmodule

// File: rtl/bank_addr_dp.sv
module bank_addr_dp
  import bank_addr_pkg::*;
#(
  parameter int unsigned OFS_W      = 5,
  parameter int unsigned BANK_W     = 2,
  parameter int unsigned DATA_W     = 8,
  parameter bit          HAS_PORT_C = 1'b1,
  localparam int unsigned ADDR_W    = OFS_W + BANK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  addrCtrl_t         ctrl,
  input  logic [OFS_W-1:0]  regField,
  input  logic [ADDR_W-1:0] wrData,
  output logic [OFS_W-1:0]  ptrOfs,
  output logic [ADDR_W-1:0] physAddr,
  output logic              selTimer,
  output logic              selPc,
  output logic              selStatus,
  output logic              selPtr,
  output logic              selPortA,
  output logic              selPortB,
  output logic              selPortC,
  output logic              selRam,
  output logic [DATA_W-1:0] ptrRdData
);

  localparam int unsigned PAD_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] ptrReg;
  logic [OFS_W-1:0]  effOfs;
  logic [BANK_W-1:0] effBank;
  logic              ramHalf;

  // Pointer storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           ptrReg <= '0;
    else if (ctrl.ptrWe) ptrReg <= wrData;
  end

  assign ptrOfs    = ptrReg[OFS_W-1:0];
  assign ptrRdData = {{PAD_W{1'b1}}, ptrReg};

  // Address formation: the upper half of an offset keeps its bank
  always_comb begin
    effOfs   = ctrl.useInd ? ptrReg[OFS_W-1:0] : regField;
    effBank  = ctrl.useInd ? ptrReg[ADDR_W-1:OFS_W] : '0;
    ramHalf  = effOfs[OFS_W-1];
    physAddr = ramHalf ? {effBank, effOfs} : {{BANK_W{1'b0}}, effOfs};
  end

  // Target decode
  logic portCRam;
  generate
    if (HAS_PORT_C) begin : g_portc
      assign selPortC = (physAddr == ADDR_W'(SLOT_PORTC));
      assign portCRam = 1'b0;
    end else begin : g_no_portc
      assign selPortC = 1'b0;
      assign portCRam = (physAddr == ADDR_W'(SLOT_PORTC));
    end
  endgenerate

  assign selTimer  = (physAddr == ADDR_W'(SLOT_TIMER));
  assign selPc     = (physAddr == ADDR_W'(SLOT_PC));
  assign selStatus = (physAddr == ADDR_W'(SLOT_STATUS));
  assign selPtr    = (physAddr == ADDR_W'(SLOT_PTR));
  assign selPortA  = (physAddr == ADDR_W'(SLOT_PORTA));
  assign selPortB  = (physAddr == ADDR_W'(SLOT_PORTB));
  assign selRam    = (physAddr >= ADDR_W'(SLOT_RAM0)) || portCRam;

  // ---------------- assertions ----------------
  assert_one_target_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.nullAcc, selTimer, selPc, selStatus, selPtr,
              selPortA, selPortB, selPortC, selRam}));

  assert_null_addr_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.nullAcc |-> (physAddr == '0));

  assert_direct_bank0_R1: assert property (@(posedge clk) disable iff (!rstN)
    (regField != '0) |-> (physAddr[ADDR_W-1:OFS_W] == '0));

  assert_fold_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.useInd && !ptrOfs[OFS_W-1]) |-> (physAddr[ADDR_W-1:OFS_W-1] == '0));

  assert_ptr_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.ptrWe |=> $stable(ptrRdData));

  assert_ptr_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.ptrWe |=> (ptrRdData[ADDR_W-1:0] == $past(wrData)));

  assert_null_no_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.nullAcc |-> !ctrl.ptrWe);

endmodule

// File: rtl/bank_addr_resolver.sv
module bank_addr_resolver
  import bank_addr_pkg::*;
#(
  parameter int unsigned OFS_W      = 5,
  parameter int unsigned BANK_W     = 2,
  parameter int unsigned DATA_W     = 8,
  parameter bit          HAS_PORT_C = 1'b1,
  localparam int unsigned ADDR_W    = OFS_W + BANK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [OFS_W-1:0]  regField,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] wrData,
  output logic [ADDR_W-1:0] physAddr,
  output logic              selTimer,
  output logic              selPc,
  output logic              selStatus,
  output logic              selPtr,
  output logic              selPortA,
  output logic              selPortB,
  output logic              selPortC,
  output logic              selRam,
  output logic              nullAcc,
  output logic [DATA_W-1:0] ptrRdData
);

  addrCtrl_t        ctrl;
  logic [OFS_W-1:0] ptrOfs;

  bank_addr_ctrl #(.OFS_W(OFS_W)) ctrl_i (
    .regField (regField),
    .ptrOfs   (ptrOfs),
    .accValid (accValid),
    .accWrite (accWrite),
    .ctrl     (ctrl)
  );

  bank_addr_dp #(
    .OFS_W(OFS_W), .BANK_W(BANK_W), .DATA_W(DATA_W), .HAS_PORT_C(HAS_PORT_C)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .regField  (regField),
    .wrData    (wrData),
    .ptrOfs    (ptrOfs),
    .physAddr  (physAddr),
    .selTimer  (selTimer),
    .selPc     (selPc),
    .selStatus (selStatus),
    .selPtr    (selPtr),
    .selPortA  (selPortA),
    .selPortB  (selPortB),
    .selPortC  (selPortC),
    .selRam    (selRam),
    .ptrRdData (ptrRdData)
  );

  assign nullAcc = ctrl.nullAcc;

endmodule

// File: tb/bank_addr_resolver_tb.sv
module bank_addr_resolver_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] regField = '0;
  logic       accValid = 1'b0;
  logic       accWrite = 1'b0;
  logic [6:0] wrData = '0;

  logic [6:0] physAddr, physAddrN;
  logic selTimer, selPc, selStatus, selPtr, selPortA, selPortB, selPortC, selRam, nullAcc;
  logic selTimerN, selPcN, selStatusN, selPtrN, selPortAN, selPortBN, selPortCN, selRamN, nullAccN;
  logic [7:0] ptrRdData, ptrRdDataN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  bank_addr_resolver dut_i (
    .clk(clk), .rstN(rstN), .regField(regField), .accValid(accValid),
    .accWrite(accWrite), .wrData(wrData), .physAddr(physAddr),
    .selTimer(selTimer), .selPc(selPc), .selStatus(selStatus), .selPtr(selPtr),
    .selPortA(selPortA), .selPortB(selPortB), .selPortC(selPortC),
    .selRam(selRam), .nullAcc(nullAcc), .ptrRdData(ptrRdData)
  );

  bank_addr_resolver #(.HAS_PORT_C(1'b0)) dut_noc_i (
    .clk(clk), .rstN(rstN), .regField(regField), .accValid(accValid),
    .accWrite(accWrite), .wrData(wrData), .physAddr(physAddrN),
    .selTimer(selTimerN), .selPc(selPcN), .selStatus(selStatusN), .selPtr(selPtrN),
    .selPortA(selPortAN), .selPortB(selPortBN), .selPortC(selPortCN),
    .selRam(selRamN), .nullAcc(nullAccN), .ptrRdData(ptrRdDataN)
  );

  // sel packing: {null, ram, C, B, A, ptr, status, pc, timer}
  function automatic logic [8:0] selMain();
    return {nullAcc, selRam, selPortC, selPortB, selPortA, selPtr, selStatus, selPc, selTimer};
  endfunction
  function automatic logic [8:0] selNoC();
    return {nullAccN, selRamN, selPortCN, selPortBN, selPortAN, selPtrN, selStatusN, selPcN, selTimerN};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Load pointer through a direct write to slot 04h
  task automatic setPtr(input logic [6:0] v);
    @(negedge clk);
    regField = 5'h04; accValid = 1'b1; accWrite = 1'b1; wrData = v;
    @(negedge clk);
    accValid = 1'b0; accWrite = 1'b0;
  endtask

  // {ptr[6:0], regField[4:0], expAddr[6:0], expSel[8:0]}
  localparam logic [27:0] VEC [18] = '{
    {7'h00, 5'h01, 7'h01, 9'h001},  // R1 R5 timer
    {7'h00, 5'h02, 7'h02, 9'h002},  // R5 pc
    {7'h00, 5'h03, 7'h03, 9'h004},  // R5 status
    {7'h00, 5'h05, 7'h05, 9'h010},  // R5 port A
    {7'h00, 5'h06, 7'h06, 9'h020},  // R5 port B
    {7'h00, 5'h07, 7'h07, 9'h040},  // R5 port C
    {7'h00, 5'h08, 7'h08, 9'h080},  // R5 first RAM
    {7'h00, 5'h1F, 7'h1F, 9'h080},  // R1 last bank-0 RAM
    {7'h23, 5'h00, 7'h03, 9'h004},  // R3 bank1 fold -> status
    {7'h5F, 5'h00, 7'h5F, 9'h080},  // R4 bank2 upper
    {7'h71, 5'h00, 7'h71, 9'h080},  // R4 bank3 upper
    {7'h3A, 5'h00, 7'h3A, 9'h080},  // R4 bank1 upper
    {7'h4C, 5'h00, 7'h0C, 9'h080},  // R3 bank2 fold -> shared RAM
    {7'h40, 5'h00, 7'h00, 9'h100},  // R6 null via bank2
    {7'h65, 5'h00, 7'h05, 9'h010},  // R3 bank3 fold -> port A
    {7'h24, 5'h00, 7'h04, 9'h008},  // R2 indirect -> pointer
    {7'h7F, 5'h1F, 7'h1F, 9'h080},  // R1 direct ignores bank
    {7'h10, 5'h00, 7'h10, 9'h080}   // R4 bank0 upper
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check("R9 reset pointer", 32'(ptrRdData), 32'h80);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 reset pointer after release", 32'(ptrRdData), 32'h80);

    // Table walk (R1..R6)
    for (int i = 0; i < 18; i++) begin
      logic [27:0] v;
      v = VEC[i];
      setPtr(v[27:21]);
      regField = v[20:16];
      #1;
      check($sformatf("R2/R4 vec %0d addr", i), 32'(physAddr), 32'(v[15:9]));
      check($sformatf("R5/R6 vec %0d sel", i), 32'(selMain()), 32'(v[8:0]));
    end

    // R11: no port C variant
    setPtr(7'h00);
    regField = 5'h07; #1;
    check("R11 noC 07h sel", 32'(selNoC()), 32'h080);
    check("R11 noC addr", 32'(physAddrN), 32'h07);
    setPtr(7'h67);
    regField = 5'h00; #1;
    check("R11 noC indirect 07h sel", 32'(selNoC()), 32'h080);
    check("R5 main indirect 07h sel", 32'(selMain()), 32'h040);

    // R7 direct write, R8 bit 7 reads 1
    setPtr(7'h35);
    check("R7 R8 direct write", 32'(ptrRdData), 32'hB5);
    // R7 indirect write through the pointer onto itself
    setPtr(7'h24);
    @(negedge clk);
    regField = 5'h00; accValid = 1'b1; accWrite = 1'b1; wrData = 7'h12;
    @(negedge clk);
    accValid = 1'b0; accWrite = 1'b0;
    check("R7 indirect write", 32'(ptrRdData), 32'h92);

    // R6 null write ignored
    setPtr(7'h40);
    @(negedge clk);
    regField = 5'h00; accValid = 1'b1; accWrite = 1'b1; wrData = 7'h55;
    @(negedge clk);
    accValid = 1'b0; accWrite = 1'b0;
    check("R6 null write ignored", 32'(ptrRdData), 32'hC0);

    // R10 holds: no valid, no write, other target
    @(negedge clk);
    regField = 5'h04; accValid = 1'b0; accWrite = 1'b1; wrData = 7'h11;
    @(negedge clk);
    check("R10 no valid", 32'(ptrRdData), 32'hC0);
    accValid = 1'b1; accWrite = 1'b0;
    @(negedge clk);
    check("R10 no write", 32'(ptrRdData), 32'hC0);
    regField = 5'h05; accWrite = 1'b1;
    @(negedge clk);
    accValid = 1'b0; accWrite = 1'b0;
    check("R10 other target", 32'(ptrRdData), 32'hC0);
    check("R10 noC copy same", 32'(ptrRdDataN), 32'hC0);

    // R9 reset clears a loaded pointer
    setPtr(7'h7E);
    check("R8 full pointer", 32'(ptrRdData), 32'hFE);
    rstN = 1'b0; #1;
    check("R9 async reset", 32'(ptrRdData), 32'h80);
    @(negedge clk);
    rstN = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule